// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Port

This block is the byte-wide processor-side register port of a two-channel serial communications controller. A two-bit address chooses the channel and chooses between the control port and the data port. Registers behind the control port are reached indirectly. A control write made while the register pointer is zero loads the pointer. The next control access then reaches the register the pointer names, and the pointer falls back to zero afterwards. Each channel keeps its own bank of sixteen write registers. The vector base (pointer 2) and the master control register (pointer 9) exist once and are shared by both channels.

Two bits of the master control register trigger channel resets. Bit 7 resets channel A and bit 6 resets channel B. A channel reset reloads a few mode registers and the latched status of that channel, and it also clears the master control register. The data port sends writes to a one-cycle transmit strobe and takes read data from a per-channel receive byte input. The receive byte is acknowledged with a one-cycle strobe. The serial shifters, the baud generator and the interrupt logic sit outside this block. They are connected through the status inputs, the strobes, and the vector-base and master-control outputs.

Top module: `sercom_regport`

## Requirements
- R1: `bus_addr[2]` selects the channel (0 = A, 1 = B) and `bus_addr[1]` selects the control port (0) or the data port (1); an access reaches only the selected channel's state and inputs.
- R2: A control write while the pointer is 0 with a value of 15 or less loads the pointer with that value; a value of 16 or more leaves the pointer at 0 and changes no register.
- R3: Any read (control or data) and any control write made while the pointer is non-zero return the pointer to 0; a data-port write leaves the pointer unchanged.
- R4: A control write at a non-zero pointer stores the byte in that register of the addressed channel only; control reads at pointers 12 and 13 return that channel's registers 12 and 13 (baud divisor bytes), and a read at pointer 9 returns register 13.
- R5: Control reads at pointers 11 and 15 both return register 15 ANDed with 0xFA; reads at pointers 1, 3, 5, 6, 7, 10 and 14 return 0.
- R6: Registers 2 and 9 are single copies written from either channel; `vec_base` and `master_ctl` show them, and a control read at pointer 2 on either channel returns the vector base.
- R7: Writing register 9 with bit 7 set resets channel A and with bit 6 set resets channel B; the reset channel's register 15 becomes 0xF8 (14 becomes 0xA0, 11 becomes 0x08) and its latched status becomes 0x04, the other channel is untouched, and register 9 reads back as 0.
- R8: For each channel, `rts` equals bit 1 and `dtr` equals bit 7 of that channel's register 5.
- R9: A control read at pointer 0 returns the live status byte, with bit 5 = `cts_in`, bit 2 = `tx_empty`, bit 0 = `rx_avail` and all other bits 0; the same byte is latched and returned by a control read at pointer 4.
- R10: A data-port write, or a control write at pointer 8, raises the channel's `tx_stb` bit for exactly the one cycle after the write, with `tx_byte` holding the written byte.
- R11: A data-port read, or a control read at pointer 8, returns the channel's `rx_byte` and raises its `rx_ack` bit during the access cycle; `rx_ack` is 0 for all other accesses.
- R12: A synchronous active-low reset sets the pointer, the vector base, the master control register, `tx_stb`, `rts` and `dtr` to 0, and leaves both channels in the R7 reset pattern (register 15 = 0xF8, latched status = 0x04).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | [2] channel, [1] control/data |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, valid during a read access |
| cts_in | input | 2 | Clear-to-send per channel |
| tx_empty | input | 2 | Transmit buffer empty per channel |
| rx_avail | input | 2 | Receive character available per channel |
| rx_byte | input | 16 | Received byte per channel ([1] = B) |
| rx_ack | output | 2 | Receive byte taken, per channel |
| tx_stb | output | 2 | Transmit byte strobe, per channel |
| tx_byte | output | 8 | Byte to transmit |
| rts | output | 2 | Request-to-send per channel |
| dtr | output | 2 | Data-terminal-ready per channel |
| vec_base | output | 8 | Shared vector base register |
| master_ctl | output | 8 | Shared master control register |

## Verification
The pointer mechanism is driven with three kinds of control sequence: a pointer load followed by a read, a pointer load followed by a data write and then a read, and a command-range value followed by a read. Together these separate a pointer that is consumed from one that survives a data write or is never loaded. Each channel gets its own divisor bytes, so leakage between channels shows up on readback. Different status input patterns are used for the live read and the latched read, which separates the two paths. Channel resets are issued from the opposite channel while the other channel holds non-reset values, which shows that each reset hits only its target channel and goes through the shared register.

// File: rtl/sercom_pkg.sv
// Shared constants and types for the serial controller register port.
// Assumes byte-wide registers and sixteen register slots per channel.
package sercom_pkg;
    localparam int NCH  = 2;
    localparam int DW   = 8;
    localparam int NREG = 16;
    localparam int PW   = $clog2(NREG);

    localparam logic [PW-1:0] IDX_VEC    = PW'(2);
    localparam logic [PW-1:0] IDX_STAT   = PW'(4);
    localparam logic [PW-1:0] IDX_LINE   = PW'(5);
    localparam logic [PW-1:0] IDX_DATA   = PW'(8);
    localparam logic [PW-1:0] IDX_MASTER = PW'(9);
    localparam logic [PW-1:0] IDX_R11    = PW'(11);
    localparam logic [PW-1:0] IDX_BRG_LO = PW'(12);
    localparam logic [PW-1:0] IDX_BRG_HI = PW'(13);
    localparam logic [PW-1:0] IDX_R14    = PW'(14);
    localparam logic [PW-1:0] IDX_MODE   = PW'(15);

    localparam logic [DW-1:0] RST_MODE  = 8'hF8;
    localparam logic [DW-1:0] RST_R14   = 8'hA0;
    localparam logic [DW-1:0] RST_R11   = 8'h08;
    localparam logic [DW-1:0] RST_STAT  = 8'h04;
    localparam logic [DW-1:0] MODE_MASK = 8'hFA;

    localparam int RTS_BIT    = 1;
    localparam int DTR_BIT    = 7;
    localparam int RST_A_BIT  = 7;
    localparam int RST_B_BIT  = 6;

    // Decoded bus access
    typedef struct packed {
        logic chan;
        logic is_data;
    } acc_t;
endpackage

// File: rtl/sercom_chan_regs.sv
// Register bank of one channel: sixteen write registers plus a latched
// status byte. Assumes at most one write and one channel reset per cycle;
// a channel reset wins over a write in the same cycle.
module sercom_chan_regs
    import sercom_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          chan_rst,
    input  logic          stat_ld,
    input  logic [DW-1:0] stat_in,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_byte,
    output logic [DW-1:0] stat_q,
    output logic          rts,
    output logic          dtr
);
    logic [DW-1:0] regs_q [NREG];

    // Reset value of each register slot
    function automatic logic [DW-1:0] rst_val(input int idx);
        case (idx)
            int'(IDX_MODE): rst_val = RST_MODE;
            int'(IDX_R14):  rst_val = RST_R14;
            int'(IDX_R11):  rst_val = RST_R11;
            default:        rst_val = '0;
        endcase
    endfunction

    // Register storage with full and channel-only reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= rst_val(i);
        end else if (chan_rst) begin
            regs_q[IDX_MODE] <= RST_MODE;
            regs_q[IDX_R14]  <= RST_R14;
            regs_q[IDX_R11]  <= RST_R11;
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    // Latched status copy
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) stat_q <= RST_STAT;
        else if (stat_ld)       stat_q <= stat_in;
    end

    // Read port and line-control outputs
    always_comb begin
        rd_byte = regs_q[rd_idx];
        rts     = regs_q[IDX_LINE][RTS_BIT];
        dtr     = regs_q[IDX_LINE][DTR_BIT];
    end

    // R7
    chan_rst_stat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (stat_q == RST_STAT));
    // R8
    rts_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !chan_rst && wr_idx == IDX_LINE) |=> (rts == $past(wr_data[RTS_BIT])));
endmodule

// File: rtl/sercom_ptr.sv
// One-shot register pointer. Loaded by a small control write at pointer 0,
// cleared by any read or by a control write at a non-zero pointer.
// Assumes at most one access per cycle.
module sercom_ptr
    import sercom_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_wr,
    input  logic          acc_data,
    input  logic [DW-1:0] wdata,
    output logic [PW-1:0] ptr_q
);
    logic is_ptr_val;
    logic [PW-1:0] ptr_d;

    // Next pointer value
    always_comb begin
        is_ptr_val = (wdata[DW-1:PW] == '0);
        ptr_d      = ptr_q;
        if (acc_en) begin
            if (!acc_wr)                 ptr_d = '0;
            else if (!acc_data) begin
                if (ptr_q != '0)         ptr_d = '0;
                else if (is_ptr_val)     ptr_d = wdata[PW-1:0];
            end
        end
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    // R3
    rd_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !acc_wr) |=> (ptr_q == '0));
    // R3
    data_wr_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && acc_data) |=> $stable(ptr_q));
    // R3
    reg_wr_clears_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && !acc_data && ptr_q != '0) |=> (ptr_q == '0));
endmodule

// File: rtl/sercom_regport.sv
// Processor register port of a two-channel serial controller: address
// decode, indirect pointer, per-channel banks, shared vector/master
// registers, channel resets, transmit strobe and receive acknowledge.
// Assumes a single-cycle access with combinational read data.
module sercom_regport
    import sercom_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_req,
    input  logic                    bus_wr,
    input  logic [2:1]              bus_addr,
    input  logic [7:0]              bus_wdata,
    output logic [7:0]              bus_rdata,
    input  logic [1:0]              cts_in,
    input  logic [1:0]              tx_empty,
    input  logic [1:0]              rx_avail,
    input  logic [1:0][7:0]         rx_byte,
    output logic [1:0]              rx_ack,
    output logic [1:0]              tx_stb,
    output logic [7:0]              tx_byte,
    output logic [1:0]              rts,
    output logic [1:0]              dtr,
    output logic [7:0]              vec_base,
    output logic [7:0]              master_ctl
);
    acc_t              acc;
    logic              rd_acc, wr_acc, reg_wr, master_wr, vec_wr, tx_fire;
    logic [PW-1:0]     ptr_q, rd_idx;
    logic [NCH-1:0]    chan_rst;
    logic [NCH-1:0][DW-1:0] chan_rd, chan_stat, live_stat;

    // Access decode
    always_comb begin
        acc.chan    = bus_addr[2];
        acc.is_data = bus_addr[1];
        rd_acc      = bus_req && !bus_wr;
        wr_acc      = bus_req && bus_wr;
        reg_wr      = wr_acc && !acc.is_data && (ptr_q != '0);
        master_wr   = reg_wr && (ptr_q == IDX_MASTER);
        vec_wr      = reg_wr && (ptr_q == IDX_VEC);
        tx_fire     = wr_acc && (acc.is_data || ptr_q == IDX_DATA);
        chan_rst[0] = master_wr && bus_wdata[RST_A_BIT];
        chan_rst[1] = master_wr && bus_wdata[RST_B_BIT];
    end

    sercom_ptr u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_en   (bus_req),
        .acc_wr   (bus_wr),
        .acc_data (acc.is_data),
        .wdata    (bus_wdata),
        .ptr_q    (ptr_q)
    );

    // Read aliases: pointer 9 shows register 13, pointer 11 shows 15
    always_comb begin
        case (ptr_q)
            IDX_MASTER: rd_idx = IDX_BRG_HI;
            IDX_R11:    rd_idx = IDX_MODE;
            default:    rd_idx = ptr_q;
        endcase
    end

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic sel;
        assign sel          = (acc.chan == c[0]);
        assign live_stat[c] = {2'b00, cts_in[c], 2'b00, tx_empty[c], 1'b0, rx_avail[c]};
        assign rx_ack[c]    = rd_acc && sel && (acc.is_data || ptr_q == IDX_DATA);

        sercom_chan_regs u_regs (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (reg_wr && sel),
            .wr_idx   (ptr_q),
            .wr_data  (bus_wdata),
            .chan_rst (chan_rst[c]),
            .stat_ld  (rd_acc && sel && !acc.is_data && ptr_q == '0),
            .stat_in  (live_stat[c]),
            .rd_idx   (rd_idx),
            .rd_byte  (chan_rd[c]),
            .stat_q   (chan_stat[c]),
            .rts      (rts[c]),
            .dtr      (dtr[c])
        );

        // Transmit strobe, one cycle after the write
        always_ff @(posedge clk) begin
            if (!rst_n) tx_stb[c] <= 1'b0;
            else        tx_stb[c] <= tx_fire && sel;
        end
    end

    // Transmit byte holding register
    always_ff @(posedge clk) begin
        if (!rst_n)       tx_byte <= '0;
        else if (tx_fire) tx_byte <= bus_wdata;
    end

    // Shared vector base and master control registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_base   <= '0;
            master_ctl <= '0;
        end else begin
            if (vec_wr) vec_base <= bus_wdata;
            if (master_wr)
                master_ctl <= (|chan_rst) ? '0 : bus_wdata;
        end
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (rd_acc) begin
            if (acc.is_data) bus_rdata = rx_byte[acc.chan];
            else begin
                case (ptr_q)
                    PW'(0):                 bus_rdata = live_stat[acc.chan];
                    IDX_VEC:                bus_rdata = vec_base;
                    IDX_STAT:               bus_rdata = chan_stat[acc.chan];
                    IDX_DATA:               bus_rdata = rx_byte[acc.chan];
                    IDX_MASTER, IDX_BRG_LO,
                    IDX_BRG_HI:             bus_rdata = chan_rd[acc.chan];
                    IDX_R11, IDX_MODE:      bus_rdata = chan_rd[acc.chan] & MODE_MASK;
                    default:                bus_rdata = '0;
                endcase
            end
        end
    end

    // R10
    tx_one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tx_stb));
    // R11
    rx_one_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rx_ack));
    // R7
    master_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_wr && (bus_wdata[RST_A_BIT] || bus_wdata[RST_B_BIT])) |=> (master_ctl == '0));
    // R10
    tx_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|tx_stb) |-> (tx_byte == $past(bus_wdata)));
endmodule

// File: tb/sercom_regport_tb.sv
// Directed bench for the serial controller register port.
module sercom_regport_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, bus_wr = 1'b0;
    logic [2:1] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [1:0] cts_in = '0, tx_empty = 2'b11, rx_avail = '0;
    logic [1:0][7:0] rx_byte = '0;
    logic [1:0] rx_ack, tx_stb, rts, dtr;
    logic [7:0] tx_byte, vec_base, master_ctl;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sercom_regport dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cts_in(cts_in), .tx_empty(tx_empty), .rx_avail(rx_avail),
        .rx_byte(rx_byte), .rx_ack(rx_ack), .tx_stb(tx_stb), .tx_byte(tx_byte),
        .rts(rts), .dtr(dtr), .vec_base(vec_base), .master_ctl(master_ctl)
    );

    task automatic chk(input string rq, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", rq, act, exp);
        end
    endtask

    task automatic bus_write(input logic ch, input logic dat, input logic [7:0] v);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b1; bus_addr = {ch, dat}; bus_wdata = v;
        @(negedge clk);
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic ch, input logic dat,
                            output logic [7:0] v, output logic [1:0] ack);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = 1'b0; bus_addr = {ch, dat};
        #1;
        v = bus_rdata; ack = rx_ack;
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic wreg(input logic ch, input logic [3:0] idx, input logic [7:0] v);
        bus_write(ch, 1'b0, {4'h0, idx});
        bus_write(ch, 1'b0, v);
    endtask

    task automatic rreg(input logic ch, input logic [3:0] idx, output logic [7:0] v);
        logic [1:0] ack;
        if (idx != 0) bus_write(ch, 1'b0, {4'h0, idx});
        bus_read(ch, 1'b0, v, ack);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        chk("R12 tx_stb", {6'b0, tx_stb}, 8'h00);
        chk("R12 rts/dtr", {4'b0, rts, dtr}, 8'h00);
        chk("R12 vec_base", vec_base, 8'h00);
        chk("R12 master_ctl", master_ctl, 8'h00);
        rreg(1'b0, 4'd15, v); chk("R12 A reg15", v, 8'hF8);
        rreg(1'b1, 4'd15, v); chk("R12 B reg15", v, 8'hF8);
        rreg(1'b0, 4'd4, v);  chk("R12 A status latch", v, 8'h04);
        rreg(1'b1, 4'd4, v);  chk("R12 B status latch", v, 8'h04);
    endtask

    task automatic t_status;
        logic [7:0] v;
        cts_in = 2'b01; tx_empty = 2'b01; rx_avail = 2'b01;
        rreg(1'b0, 4'd0, v); chk("R9 live A all set", v, 8'h25);
        cts_in = 2'b00; tx_empty = 2'b00; rx_avail = 2'b00;
        rreg(1'b0, 4'd4, v); chk("R9 latched A", v, 8'h25);
        rreg(1'b1, 4'd4, v); chk("R1 B latch untouched", v, 8'h04);
        cts_in = 2'b10; tx_empty = 2'b01; rx_avail = 2'b00;
        rreg(1'b1, 4'd0, v); chk("R9 live B cts only", v, 8'h20);
        rreg(1'b1, 4'd4, v); chk("R9 latched B", v, 8'h20);
    endtask

    task automatic t_banks;
        logic [7:0] v;
        wreg(1'b0, 4'd12, 8'h5A); wreg(1'b0, 4'd13, 8'h3C);
        wreg(1'b1, 4'd12, 8'hA5); wreg(1'b1, 4'd13, 8'hC3);
        rreg(1'b0, 4'd12, v); chk("R4 A reg12", v, 8'h5A);
        rreg(1'b0, 4'd13, v); chk("R4 A reg13", v, 8'h3C);
        rreg(1'b1, 4'd12, v); chk("R1 B reg12", v, 8'hA5);
        rreg(1'b1, 4'd9, v);  chk("R4 B ptr9 alias", v, 8'hC3);
    endtask

    task automatic t_mode;
        logic [7:0] v;
        wreg(1'b0, 4'd15, 8'hFF);
        rreg(1'b0, 4'd15, v); chk("R5 ptr15 mask", v, 8'hFA);
        rreg(1'b0, 4'd11, v); chk("R5 ptr11 alias", v, 8'hFA);
        wreg(1'b0, 4'd7, 8'h66);
        rreg(1'b0, 4'd7, v);  chk("R5 ptr7 reads 0", v, 8'h00);
        rreg(1'b0, 4'd3, v);  chk("R5 ptr3 reads 0", v, 8'h00);
    endtask

    task automatic t_pointer;
        logic [7:0] v;
        logic [1:0] ack;
        cts_in = 2'b01; tx_empty = 2'b01; rx_avail = 2'b01;
        bus_write(1'b0, 1'b0, 8'h2C);
        bus_read(1'b0, 1'b0, v, ack); chk("R2 command not a pointer", v, 8'h25);
        rreg(1'b0, 4'd12, v); chk("R2 reg12 unchanged", v, 8'h5A);
        bus_write(1'b0, 1'b0, 8'h0C);
        bus_write(1'b0, 1'b1, 8'h44);
        bus_read(1'b0, 1'b0, v, ack); chk("R3 data write keeps ptr", v, 8'h5A);
        bus_read(1'b0, 1'b0, v, ack); chk("R3 read clears ptr", v, 8'h25);
        wreg(1'b0, 4'd13, 8'h3C);
        bus_read(1'b0, 1'b0, v, ack); chk("R3 reg write clears ptr", v, 8'h25);
    endtask

    task automatic t_shared;
        logic [7:0] v;
        wreg(1'b1, 4'd2, 8'h77);
        chk("R6 vec_base", vec_base, 8'h77);
        rreg(1'b0, 4'd2, v); chk("R6 A reads vec", v, 8'h77);
        rreg(1'b1, 4'd2, v); chk("R6 B reads vec", v, 8'h77);
        wreg(1'b0, 4'd9, 8'h09);
        chk("R6 master_ctl", master_ctl, 8'h09);
    endtask

    task automatic t_chreset;
        logic [7:0] v;
        wreg(1'b0, 4'd15, 8'h00); wreg(1'b1, 4'd15, 8'h00);
        cts_in = 2'b11; tx_empty = 2'b11; rx_avail = 2'b00;
        rreg(1'b0, 4'd0, v); rreg(1'b1, 4'd0, v);
        wreg(1'b1, 4'd9, 8'h80);
        chk("R7 master cleared", master_ctl, 8'h00);
        rreg(1'b0, 4'd15, v); chk("R7 A reg15 reset", v, 8'hF8);
        rreg(1'b0, 4'd4, v);  chk("R7 A status reset", v, 8'h04);
        rreg(1'b1, 4'd15, v); chk("R7 B untouched reg15", v, 8'h00);
        rreg(1'b1, 4'd4, v);  chk("R7 B untouched status", v, 8'h24);
        wreg(1'b0, 4'd9, 8'h40);
        rreg(1'b1, 4'd15, v); chk("R7 B reg15 reset", v, 8'hF8);
        rreg(1'b1, 4'd4, v);  chk("R7 B status reset", v, 8'h04);
        rreg(1'b0, 4'd12, v); chk("R7 A divisor kept", v, 8'h5A);
    endtask

    task automatic t_line;
        wreg(1'b0, 4'd5, 8'h82);
        chk("R8 A rts/dtr", {6'b0, rts[0], dtr[0]}, 8'h03);
        chk("R8 B idle", {6'b0, rts[1], dtr[1]}, 8'h00);
        wreg(1'b1, 4'd5, 8'h02);
        chk("R8 B rts only", {6'b0, rts[1], dtr[1]}, 8'h02);
        wreg(1'b0, 4'd5, 8'h80);
        chk("R8 A dtr only", {6'b0, rts[0], dtr[0]}, 8'h01);
    endtask

    task automatic t_tx;
        bus_write(1'b1, 1'b1, 8'h3E);
        chk("R10 data write strobe", {6'b0, tx_stb}, 8'h02);
        chk("R10 data write byte", tx_byte, 8'h3E);
        @(negedge clk);
        chk("R10 strobe one cycle", {6'b0, tx_stb}, 8'h00);
        wreg(1'b0, 4'd8, 8'hC1);
        chk("R10 ptr8 strobe", {6'b0, tx_stb}, 8'h01);
        chk("R10 ptr8 byte", tx_byte, 8'hC1);
    endtask

    task automatic t_rx;
        logic [7:0] v;
        logic [1:0] ack;
        rx_byte[0] = 8'h11; rx_byte[1] = 8'h99;
        bus_read(1'b1, 1'b1, v, ack);
        chk("R11 B data read", v, 8'h99);
        chk("R11 B ack", {6'b0, ack}, 8'h02);
        bus_write(1'b0, 1'b0, 8'h08);
        bus_read(1'b0, 1'b0, v, ack);
        chk("R11 A ptr8 read", v, 8'h11);
        chk("R11 A ack", {6'b0, ack}, 8'h01);
        bus_read(1'b0, 1'b0, v, ack);
        chk("R11 no ack on status read", {6'b0, ack}, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_status();
        t_banks();
        t_mode();
        t_pointer();
        t_shared();
        t_chreset();
        t_line();
        t_tx();
        t_rx();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule